// File: doc/BRIEF.md
# Three-Phase PWM Compare Unit

This block produces pulse-width-modulated drive for a three-phase motor bridge. A single 16-bit period timer paces three compare channels. In edge-aligned mode the timer counts up and wraps to zero after it reaches the period value. In center-aligned mode it counts up to the period value and then back down to zero. Each channel compares the timer against its own compare value and has an active/passive state. That state, combined with a pair of passive (initial) level bits, drives a primary output and a secondary output.

Software reaches the block through a small write port. The compare values and the six passive-level bits are not written directly. Software writes them into shadow copies, then arms a transfer. The transfer copies them into the working registers at the next timer boundary, so the PWM waveform never changes in the middle of a period.

A trap input, synchronized inside the block, forces all six outputs to their passive levels. The block also raises one-cycle event pulses for zero match, period match and each channel's compare match, which can be used as interrupt requests.

Top module: `pwm3_cmp_unit`

## Requirements
- R1: After synchronous reset the timer is stopped at zero. The period register holds its reset default. All compare values and passive-level bits are zero, so every output and every event pulse is 0.
- R2: The write port decodes these addresses. Address 0 is control: bit0 run, bit1 center mode, bit2 arm transfer (write 1 to set), bit3 trap disable. Address 1 is the period. Addresses 2, 3 and 4 are the compare shadows of channels 0, 1 and 2. Address 5 holds the passive-level shadow: bits 2:0 are the primary outputs of channels 0..2 and bits 5:3 their secondary outputs. While run is 0 the timer is held at 0. In edge mode a running timer goes 0,1,..,P and then back to 0.
- R3: In center mode a running timer goes 0,1,..,P,P-1,..,1,0,1,.. so one cycle spans 2P clocks.
- R4: In edge mode a compare match makes the channel active, and a period match makes it passive. When a compare match and a period match occur in the same cycle, the channel becomes passive.
- R5: In center mode a compare match while counting up makes the channel active, and one while counting down makes it passive. Every zero match returns the channel to passive, unless the channel's compare match occurs in the same cycle, in which case it becomes active. A compare match coinciding with a period match makes it passive.
- R6: A shadow transfer happens only while the arm bit is set. It occurs at a period match in edge mode, and at a zero match or a period match in center mode. Performing the transfer clears the arm bit.
- R7: The cycle that performs a transfer still compares against the old compare value. The new value is used from the next cycle on.
- R8: Passive-level bits are loaded by the same transfer, and the new levels appear on the outputs in the clock after the transfer cycle.
- R9: With channel state s (1 = active), the primary output is its passive bit XOR s and the secondary output is its passive bit XOR s. Channel state and events take effect one clock after the timer value that causes them.
- R10: The trap input passes through two flip-flops. One clock after the synchronized trap is seen high, all outputs equal their passive levels. The outputs stay forced until the first period match that occurs while the synchronized trap is low.
- R11: While the trap-disable bit is set, the trap input has no effect on the outputs, and any trap already in force is released on the next clock.
- R12: The zero, period and per-channel compare event outputs each pulse high for one clock, one clock after the timer value that caused the event, and only while the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| trap_in | input | 1 | Asynchronous trap request, active high |
| pwm_hi | output | 3 | Primary output of each channel |
| pwm_lo | output | 3 | Secondary output of each channel |
| irq_zero | output | 1 | Zero-match event pulse |
| irq_period | output | 1 | Period-match event pulse |
| irq_cmp | output | 3 | Per-channel compare-match event pulses |

## Verification
The bench sweeps every compare value from 0 up to one past the period, for several small periods, in both modes. This reaches the coincidences at the timer ends. A design that resets a channel at zero match despite a simultaneous compare match would lose a full-width pulse. One that gave priority to compare over period match would leave a channel stuck active.

Transfers are armed at arbitrary points in a running period. A design that transferred without arming, forgot to clear the arm bit, or compared against the new value in the transfer cycle would shift an edge by a whole period. Trap pulses are applied in both modes, with the disable bit both set and clear. This checks the two-clock synchronizer latency and that the outputs are released only at a period boundary.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int CNT_W  = 16;
    localparam int NCH    = 3;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_PERIOD = 3'd1,
        A_CMP0   = 3'd2,
        A_CMP1   = 3'd3,
        A_CMP2   = 3'd4,
        A_LEVEL  = 3'd5
    } reg_addr_e;

    // Control register image; bit2 (arm) is a strobe and not stored here
    typedef struct packed {
        logic tdis;
        logic center;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic zero;
        logic period;
    } tmr_evt_t;

    // Next channel state from the timer events; priority order is behaviour
    function automatic logic chan_next(input logic center, input logic up,
                                       input tmr_evt_t ev, input logic cm,
                                       input logic cur);
        if (cm && ev.period)             return 1'b0;
        else if (cm && ev.zero)          return 1'b1;
        else if (ev.period && !center)   return 1'b0;
        else if (ev.zero && center)      return 1'b0;
        else if (cm)                     return center ? up : 1'b1;
        else                             return cur;
    endfunction

endpackage

// File: rtl/pwm3_timer.sv
module pwm3_timer
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         center,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         up,
    output tmr_evt_t     evt
);

    always_comb begin
        evt.zero   = run && (cnt == '0);
        evt.period = run && (cnt == period);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (!center) begin
            up  <= 1'b1;
            cnt <= evt.period ? '0 : cnt + W'(1);
        end else if (up) begin
            if (cnt == period) begin
                cnt <= (period == '0) ? '0 : cnt - W'(1);
                up  <= 1'b0;
            end else begin
                cnt <= cnt + W'(1);
            end
        end else begin
            if (cnt == '0) begin
                cnt <= cnt + W'(1);
                up  <= 1'b1;
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm3_shadow.sv
module pwm3_shadow
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W,
    parameter int N = NCH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        cmp_we,
    input  logic                lvl_we,
    input  logic [W-1:0]        wdata,
    input  logic                arm_set,
    input  logic                xfer_point,
    output logic [N-1:0][W-1:0] cmp_act,
    output logic [2*N-1:0]      lvl_act,
    output logic                armed,
    output logic                xfer
);

    logic [N-1:0][W-1:0] cmp_sh;
    logic [2*N-1:0]      lvl_sh;

    assign xfer = armed && xfer_point;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
        end else if (arm_set) begin
            armed <= 1'b1;
        end else if (xfer) begin
            armed <= 1'b0;
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst) begin
                    cmp_sh[i]  <= '0;
                    cmp_act[i] <= '0;
                end else begin
                    if (cmp_we[i]) cmp_sh[i]  <= wdata;
                    if (xfer)      cmp_act[i] <= cmp_sh[i];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_sh  <= '0;
            lvl_act <= '0;
        end else begin
            if (lvl_we) lvl_sh  <= wdata[2*N-1:0];
            if (xfer)   lvl_act <= lvl_sh;
        end
    end

endmodule

// File: rtl/pwm3_chan.sv
module pwm3_chan
    import pwm3_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         center,
    input  logic         up,
    input  tmr_evt_t     evt,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         cm,
    output logic         st
);

    assign cm = run && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) st <= 1'b0;
        else     st <= chan_next(center, up, evt, cm, st);
    end

endmodule

// File: rtl/pwm3_trap.sv
module pwm3_trap (
    input  logic clk,
    input  logic rst,
    input  logic trap_in,
    input  logic tdis,
    input  logic period_evt,
    output logic trap_s2,
    output logic hold
);

    logic trap_s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_s1 <= 1'b0;
            trap_s2 <= 1'b0;
            hold    <= 1'b0;
        end else begin
            trap_s1 <= trap_in;
            trap_s2 <= trap_s1;
            hold    <= !tdis && (trap_s2 || (hold && !period_evt));
        end
    end

endmodule

// File: rtl/pwm3_cmp_unit.sv
module pwm3_cmp_unit
    import pwm3_pkg::*;
#(
    parameter int              W       = CNT_W,
    parameter int              N       = NCH,
    parameter int              AW      = ADDR_W,
    parameter logic [W-1:0]    PER_RST = W'(99)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          trap_in,
    output logic [N-1:0]  pwm_hi,
    output logic [N-1:0]  pwm_lo,
    output logic          irq_zero,
    output logic          irq_period,
    output logic [N-1:0]  irq_cmp
);

    ctrl_t               ctrl_q;
    logic [W-1:0]        period_q;
    logic                run, center, tdis;
    logic [W-1:0]        cnt;
    logic                up;
    tmr_evt_t            evt;
    logic [N-1:0]        cmp_we;
    logic                lvl_we, arm_set, xfer_point, xfer, armed;
    logic [N-1:0][W-1:0] cmp_act;
    logic [2*N-1:0]      lvl_act;
    logic [N-1:0]        cm_vec, st_vec;
    logic                trap_s2, trap_hold;

    assign run    = ctrl_q.run;
    assign center = ctrl_q.center;
    assign tdis   = ctrl_q.tdis;

    assign arm_set    = wr_en && (wr_addr == AW'(A_CTRL)) && wr_data[2];
    assign lvl_we     = wr_en && (wr_addr == AW'(A_LEVEL));
    assign xfer_point = evt.period || (center && evt.zero);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= PER_RST;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_CTRL)) begin
                ctrl_q.run    <= wr_data[0];
                ctrl_q.center <= wr_data[1];
                ctrl_q.tdis   <= wr_data[3];
            end
            if (wr_addr == AW'(A_PERIOD)) period_q <= wr_data;
        end
    end

    pwm3_timer #(.W(W)) u_tmr (
        .clk(clk), .rst(rst), .run(run), .center(center),
        .period(period_q), .cnt(cnt), .up(up), .evt(evt)
    );

    pwm3_shadow #(.W(W), .N(N)) u_shd (
        .clk(clk), .rst(rst), .cmp_we(cmp_we), .lvl_we(lvl_we),
        .wdata(wr_data), .arm_set(arm_set), .xfer_point(xfer_point),
        .cmp_act(cmp_act), .lvl_act(lvl_act), .armed(armed), .xfer(xfer)
    );

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            assign cmp_we[i] = wr_en && (wr_addr == AW'(A_CMP0) + AW'(i));

            pwm3_chan #(.W(W)) u_ch (
                .clk(clk), .rst(rst), .run(run), .center(center), .up(up),
                .evt(evt), .cnt(cnt), .cmp(cmp_act[i]),
                .cm(cm_vec[i]), .st(st_vec[i])
            );
        end
    endgenerate

    pwm3_trap u_trp (
        .clk(clk), .rst(rst), .trap_in(trap_in), .tdis(tdis),
        .period_evt(evt.period), .trap_s2(trap_s2), .hold(trap_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_zero   <= 1'b0;
            irq_period <= 1'b0;
            irq_cmp    <= '0;
        end else begin
            irq_zero   <= evt.zero;
            irq_period <= evt.period;
            irq_cmp    <= cm_vec;
        end
    end

    always_comb begin
        if (trap_hold) begin
            pwm_hi = lvl_act[N-1:0];
            pwm_lo = lvl_act[2*N-1:N];
        end else begin
            pwm_hi = lvl_act[N-1:0]   ^ st_vec;
            pwm_lo = lvl_act[2*N-1:N] ^ st_vec;
        end
    end

endmodule

// File: rtl/pwm3_cmp_unit_chk.sv
module pwm3_cmp_unit_chk #(
    parameter int W = 16,
    parameter int N = 3
) (
    input logic           clk,
    input logic           rst,
    input logic           run,
    input logic           center,
    input logic           up,
    input logic           tdis,
    input logic [W-1:0]   cnt,
    input logic           zm,
    input logic           pm,
    input logic [N-1:0]   cm,
    input logic [N-1:0]   st,
    input logic           armed,
    input logic           arm_set,
    input logic           xfer,
    input logic           trap_s2,
    input logic [N-1:0]   pwm_hi,
    input logic [N-1:0]   pwm_lo,
    input logic [2*N-1:0] lvl
);

    p_edge_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (run && !center && pm) |=> (cnt == '0));

    p_center_turn_r3: assert property (@(posedge clk) disable iff (rst)
        (run && center && up && pm && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

    p_period_coincide_r4: assert property (@(posedge clk) disable iff (rst)
        pm |=> ((st & $past(cm)) == '0));

    p_zero_coincide_r5: assert property (@(posedge clk) disable iff (rst)
        (center && zm && !pm) |=> ((st & $past(cm)) == $past(cm)));

    p_arm_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (xfer && !arm_set) |=> !armed);

    p_trap_forces_r10: assert property (@(posedge clk) disable iff (rst)
        (trap_s2 && !tdis) |=> (pwm_hi == lvl[N-1:0] && pwm_lo == lvl[2*N-1:N]));

endmodule

bind pwm3_cmp_unit pwm3_cmp_unit_chk #(.W(W), .N(N)) u_chk (
    .clk(clk), .rst(rst), .run(run), .center(center), .up(up), .tdis(tdis),
    .cnt(cnt), .zm(evt.zero), .pm(evt.period), .cm(cm_vec), .st(st_vec),
    .armed(armed), .arm_set(arm_set), .xfer(xfer), .trap_s2(trap_s2),
    .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .lvl(lvl_act)
);

// File: tb/pwm3_cmp_unit_tb.sv
module pwm3_cmp_unit_tb;

    localparam int PER_DEF = 99;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        trap_in = 1'b0;
    logic [2:0]  pwm_hi, pwm_lo, irq_cmp;
    logic        irq_zero, irq_period;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pwm3_cmp_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trap_in(trap_in), .pwm_hi(pwm_hi),
        .pwm_lo(pwm_lo), .irq_zero(irq_zero), .irq_period(irq_period),
        .irq_cmp(irq_cmp)
    );

    // Reference state, derived from the requirement text
    logic [15:0] m_cnt, m_per;
    logic        m_up, m_run, m_center, m_tdis, m_arm;
    logic [15:0] m_csh [3];
    logic [15:0] m_cac [3];
    logic [5:0]  m_lsh, m_lac;
    logic [2:0]  m_st;
    logic        m_s1, m_s2, m_hold;
    logic        m_iz, m_ip;
    logic [2:0]  m_ic;

    task automatic model_reset();
        m_cnt = '0; m_per = 16'(PER_DEF); m_up = 1'b1;
        m_run = 1'b0; m_center = 1'b0; m_tdis = 1'b0; m_arm = 1'b0;
        for (int i = 0; i < 3; i++) begin m_csh[i] = '0; m_cac[i] = '0; end
        m_lsh = '0; m_lac = '0; m_st = '0;
        m_s1 = 1'b0; m_s2 = 1'b0; m_hold = 1'b0;
        m_iz = 1'b0; m_ip = 1'b0; m_ic = '0;
    endtask

    task automatic model_step();
        logic zm, pm, xf;
        logic [2:0] cm, nst;
        zm = m_run && (m_cnt == 0);
        pm = m_run && (m_cnt == m_per);
        for (int i = 0; i < 3; i++) cm[i] = m_run && (m_cnt == m_cac[i]);
        xf = m_arm && (pm || (m_center && zm));
        for (int i = 0; i < 3; i++) begin
            if (cm[i] && pm)                nst[i] = 1'b0;   // R4 / R5
            else if (cm[i] && zm)           nst[i] = 1'b1;   // R5
            else if (pm && !m_center)       nst[i] = 1'b0;   // R4
            else if (zm && m_center)        nst[i] = 1'b0;   // R5
            else if (cm[i])                 nst[i] = m_center ? m_up : 1'b1;
            else                            nst[i] = m_st[i];
        end
        m_hold = !m_tdis && (m_s2 || (m_hold && !pm));
        m_s2 = m_s1;
        m_s1 = trap_in;
        m_iz = zm; m_ip = pm; m_ic = cm;
        m_st = nst;
        if (!m_run) begin
            m_cnt = '0; m_up = 1'b1;
        end else if (!m_center) begin
            m_up = 1'b1;
            m_cnt = pm ? 16'd0 : m_cnt + 16'd1;
        end else if (m_up) begin
            if (m_cnt == m_per) begin
                m_cnt = (m_per == 0) ? 16'd0 : m_cnt - 16'd1;
                m_up = 1'b0;
            end else m_cnt = m_cnt + 16'd1;
        end else begin
            if (m_cnt == 0) begin m_cnt = 16'd1; m_up = 1'b1; end
            else m_cnt = m_cnt - 16'd1;
        end
        if (xf) begin
            for (int i = 0; i < 3; i++) m_cac[i] = m_csh[i];
            m_lac = m_lsh;
        end
        if (wr_en && wr_addr == 3'd0 && wr_data[2]) m_arm = 1'b1;
        else if (xf)                                m_arm = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin m_run = wr_data[0]; m_center = wr_data[1]; m_tdis = wr_data[3]; end
                3'd1: m_per = wr_data;
                3'd2: m_csh[0] = wr_data;
                3'd3: m_csh[1] = wr_data;
                3'd4: m_csh[2] = wr_data;
                3'd5: m_lsh = wr_data[5:0];
                default: ;
            endcase
        end
    endtask

    task automatic check(input string tag, input logic ok, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Called at a falling edge with this cycle's inputs already driven
    task automatic cyc(input string tag);
        logic [2:0] eh, el;
        eh = m_hold ? m_lac[2:0] : (m_lac[2:0] ^ m_st);
        el = m_hold ? m_lac[5:3] : (m_lac[5:3] ^ m_st);
        check(tag, {pwm_lo, pwm_hi} == {el, eh}, "outputs",
              16'({pwm_lo, pwm_hi}), 16'({el, eh}));
        check(tag, {irq_zero, irq_period, irq_cmp} == {m_iz, m_ip, m_ic}, "events",
              16'({irq_zero, irq_period, irq_cmp}), 16'({m_iz, m_ip, m_ic}));
        model_step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) cyc(tag);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check("R1", pwm_hi == 3'b0 && pwm_lo == 3'b0, "reset outputs",
              16'({pwm_lo, pwm_hi}), 16'd0);
        check("R1", {irq_zero, irq_period, irq_cmp} == 5'b0, "reset events",
              16'({irq_zero, irq_period, irq_cmp}), 16'd0);
        idle(4, "R1");

        // R2/R4/R9: edge mode sweep over periods and all compare values
        wr(3'd5, 16'b111_000, "R9");
        for (int p = 2; p <= 4; p++) begin
            wr(3'd1, 16'(p), "R2");
            for (int c = 0; c <= p + 1; c++) begin
                wr(3'd2, 16'(c), "R4");
                wr(3'd3, 16'((c + 2) % (p + 2)), "R4");
                wr(3'd4, 16'(p + 1 - c), "R4");
                wr(3'd0, 16'b0101, "R2");
                idle(4 * (p + 1), "R4");
                wr(3'd0, 16'b0000, "R2");
            end
        end

        // R3/R5: center mode sweep
        wr(3'd5, 16'b010_101, "R9");
        for (int p = 2; p <= 4; p++) begin
            wr(3'd1, 16'(p), "R3");
            for (int c = 0; c <= p + 1; c++) begin
                wr(3'd2, 16'(c), "R5");
                wr(3'd3, 16'((c + 1) % (p + 2)), "R5");
                wr(3'd4, 16'(p - (c % (p + 1))), "R5");
                wr(3'd0, 16'b0111, "R3");
                idle(3 * 2 * p + 2, "R5");
                wr(3'd0, 16'b0000, "R3");
            end
        end

        // R6/R7/R8: shadow writes without arming, then arming at varied points
        for (int m = 0; m < 2; m++) begin
            wr(3'd1, 16'd5, "R6");
            wr(3'd2, 16'd1, "R6");
            wr(3'd0, 16'(m ? 16'b0111 : 16'b0101), "R6");
            idle(14, "R6");
            for (int off = 0; off < 6; off++) begin
                wr(3'd2, 16'(off), "R6");
                wr(3'd3, 16'(5 - off), "R7");
                wr(3'd5, 16'(off * 9), "R8");
                idle(13, "R6");
                idle(off, "R7");
                wr(3'd0, 16'(m ? 16'b0111 : 16'b0101), "R7");
                idle(16, "R8");
            end
            wr(3'd0, 16'b0000, "R6");
        end

        // R10: trap pulses in both modes at varied offsets and lengths
        wr(3'd5, 16'b000_111, "R10");
        wr(3'd2, 16'd2, "R10");
        wr(3'd0, 16'b0101, "R10");
        idle(14, "R10");
        for (int m = 0; m < 2; m++) begin
            wr(3'd0, 16'(m ? 16'b0011 : 16'b0001), "R10");
            for (int len = 1; len <= 4; len++) begin
                idle(len, "R10");
                trap_in = 1'b1;
                idle(len, "R10");
                trap_in = 1'b0;
                idle(15, "R10");
            end
        end

        // R11: trap disabled, then disabling while a trap is in force
        wr(3'd0, 16'b1001, "R11");
        trap_in = 1'b1;
        idle(8, "R11");
        trap_in = 1'b0;
        idle(4, "R11");
        wr(3'd0, 16'b0001, "R11");
        trap_in = 1'b1;
        idle(4, "R11");
        wr(3'd0, 16'b1001, "R11");
        idle(4, "R11");
        trap_in = 1'b0;
        idle(6, "R11");

        // R12: event pulses, then stopping keeps them low
        wr(3'd0, 16'b0011, "R12");
        idle(20, "R12");
        wr(3'd0, 16'b0000, "R12");
        idle(8, "R12");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule